// File: doc/BRIEF.md
# Password-Gated Test Mode Lockout

This block decides whether a device may enter its test modes. It keeps a two-byte password and three status fields as non-volatile state: an arm flag that shuts test access off, a bad-password flag, and a three-bit field of remaining tries. Each of them can only be programmed from 1 to 0. Power-on initialisation loads the delivery values, which are all ones. The logic reset clears only the handshake outputs and leaves the non-volatile state alone.

Software drives a protection-set operation. It raises `req` for one cycle with a target address and two data bytes. The first operation aimed at the password address stores the bytes and arms the lock. Each later operation at that address compares its bytes with the stored password. A match unlocks test modes. A mismatch burns one try. Once all three tries are gone, test access is lost for good. A one-cycle `done` pulse ends every operation, and `pass` reports its result.

Top module: `tm_lockout`

## Requirements
- R1: After power-on initialisation (`nv_init_n` low) the outputs read `st_tm_dis`=1, `st_pw_bad`=1, `st_tries`=3'b111 and `test_en`=1.
- R2: An operation at `PW_ADDR` while `st_tm_dis`=1 stores {`pw_hi`,`pw_lo`} as the password and clears `st_tm_dis` to 0. It reports `pass`=1 and leaves the tries unchanged.
- R3: An operation at `PW_ADDR` while `st_tm_dis`=0 and `st_tries`≠0, with data equal to the stored password, clears `st_pw_bad` to 0 and reports `pass`=1. The tries are unchanged and `test_en` becomes 1.
- R4: The same operation with data that differs from the password reports `pass`=0 and clears the lowest remaining try bit, so `st_tries` moves 111→110→100→000. `st_tries` never holds any other value.
- R5: While `st_tries`=000, operations at `PW_ADDR` change nothing and report `pass`=0, even when the password is correct. `test_en` stays 0 even if `st_pw_bad` was cleared earlier.
- R6: `test_en` = `st_tm_dis` OR (`st_pw_bad`=0 AND `st_tries`≠000).
- R7: An operation at any address other than `PW_ADDR` changes no state and reports `pass`=0.
- R8: `done` is 1 for exactly the cycle after each clock edge that samples `req`=1 with `rst_n`=1. `pass` is 0 whenever `done` is 0.
- R9: While `rst_n`=0, `done` and `pass` are 0 and a request changes no state.
- R10: No flag or try bit ever goes from 0 back to 1 except through power-on initialisation. A logic reset (`rst_n`) leaves all of them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous logic reset, active low; the non-volatile state is kept |
| nv_init_n | input | 1 | Asynchronous power-on initialisation of the non-volatile state, active low |
| req | input | 1 | Protection-set operation strobe, one cycle |
| addr | input | ADDR_W | Target address of the operation |
| pw_hi | input | DW | First data byte |
| pw_lo | input | DW | Second data byte |
| done | output | 1 | One-cycle end-of-operation pulse |
| pass | output | 1 | Result with `done`: 1 when stored or matched |
| test_en | output | 1 | Test modes enabled |
| st_tm_dis | output | 1 | Arm flag status (1 = lock not armed) |
| st_pw_bad | output | 1 | Password flag status (0 = password accepted) |
| st_tries | output | 3 | Remaining-tries bits |

## Verification
A logic reset and a protection-set request can occur in the same cycle. The bench provokes this by pulling `rst_n` low while it presents a request. It varies the request across a correct password, a wrong one, and a first store. The case passes only if no `done` follows and every status output still matches the bench model afterwards. This shows that the reset suppresses the operation and does not erase the non-volatile state. A further case sends a wrong password in the same operation that uses up the last try while the password flag is already cleared. The bench checks that `test_en` falls in that same cycle.

// File: rtl/tm_lockout.sv
module tm_lockout #(
  parameter int ADDR_W = 24,
  parameter int DW = 8,
  parameter logic [ADDR_W-1:0] PW_ADDR = 24'h1FFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nv_init_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     pw_hi,
  input  logic [DW-1:0]     pw_lo,
  output logic              done,
  output logic              pass,
  output logic              test_en,
  output logic              st_tm_dis,
  output logic              st_pw_bad,
  output logic [2:0]        st_tries
);
  localparam int PW_W = 2 * DW;

  logic [PW_W-1:0] pw_q;
  logic            dis_q;
  logic            bad_q;
  logic [2:0]      tries_q;

  wire             take     = req && rst_n;
  wire             hit      = take && (addr == PW_ADDR);
  wire             locked   = (tries_q == 3'b000);
  wire             match    = ({pw_hi, pw_lo} == pw_q);
  wire             do_store = hit && dis_q;
  wire             do_cmp   = hit && !dis_q && !locked;

  always_ff @(posedge clk or negedge nv_init_n) begin
    if (!nv_init_n) begin
      pw_q    <= '1;
      dis_q   <= 1'b1;
      bad_q   <= 1'b1;
      tries_q <= 3'b111;
    end else begin
      if (do_store) begin
        pw_q  <= pw_q & {pw_hi, pw_lo};
        dis_q <= 1'b0;
      end
      if (do_cmp && match)
        bad_q <= 1'b0;
      if (do_cmp && !match)
        tries_q <= tries_q & {tries_q[1:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      pass <= 1'b0;
    end else begin
      done <= req;
      pass <= do_store || (do_cmp && match);
    end
  end

  assign test_en   = dis_q || (!bad_q && !locked);
  assign st_tm_dis = dis_q;
  assign st_pw_bad = bad_q;
  assign st_tries  = tries_q;
endmodule

// File: rtl/tm_lockout_chk.sv
module tm_lockout_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       nv_init_n,
  input logic       req,
  input logic       done,
  input logic       pass,
  input logic       test_en,
  input logic       dis,
  input logic       bad,
  input logic [2:0] tries
);
  logic primed;
  always_ff @(posedge clk or negedge nv_init_n)
    if (!nv_init_n) primed <= 1'b0;
    else            primed <= 1'b1;

  p_dis_one_way_r10: assert property (@(posedge clk) disable iff (!nv_init_n || !primed)
    dis |-> $past(dis));
  p_bad_one_way_r10: assert property (@(posedge clk) disable iff (!nv_init_n || !primed)
    bad |-> $past(bad));
  p_tries_one_way_r10: assert property (@(posedge clk) disable iff (!nv_init_n || !primed)
    (tries & ~$past(tries)) == 3'b000);
  p_tries_order_r4: assert property (@(posedge clk) disable iff (!nv_init_n)
    tries == 3'b111 || tries == 3'b110 || tries == 3'b100 || tries == 3'b000);
  p_lock_blocks_r5: assert property (@(posedge clk) disable iff (!nv_init_n)
    (tries == 3'b000 && !dis) |-> !test_en);
  p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !done);
  p_pass_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);
endmodule

bind tm_lockout tm_lockout_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nv_init_n(nv_init_n), .req(req), .done(done),
  .pass(pass), .test_en(test_en), .dis(dis_q), .bad(bad_q), .tries(tries_q)
);

// File: tb/tb_tm_lockout.sv
module tb_tm_lockout;
  localparam logic [23:0] PWA = 24'h1FFE;

  logic clk = 1'b0;
  logic rst_n = 1'b0, nv_init_n = 1'b0, req = 1'b0;
  logic [23:0] addr = '0;
  logic [7:0] pw_hi = '0, pw_lo = '0;
  logic done, pass, test_en, st_tm_dis, st_pw_bad;
  logic [2:0] st_tries;

  int n_chk = 0, n_bad = 0, cyc = 0;

  logic [15:0] m_pw;
  logic m_dis, m_bad, e_pass;
  logic [2:0] m_tries;

  always #5 clk = ~clk;

  tm_lockout dut (
    .clk(clk), .rst_n(rst_n), .nv_init_n(nv_init_n), .req(req), .addr(addr),
    .pw_hi(pw_hi), .pw_lo(pw_lo), .done(done), .pass(pass), .test_en(test_en),
    .st_tm_dis(st_tm_dis), .st_pw_bad(st_pw_bad), .st_tries(st_tries)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_ten();
    return m_dis || (!m_bad && m_tries != 3'b000);
  endfunction

  task automatic check_state(string tag);
    check({tag, " st_tm_dis"}, st_tm_dis, m_dis);
    check({tag, " st_pw_bad"}, st_pw_bad, m_bad);
    check({tag, " st_tries"}, st_tries, m_tries);
    check({tag, " test_en R6"}, test_en, exp_ten());
  endtask

  task automatic model(logic [23:0] a, logic [15:0] d);
    e_pass = 1'b0;
    if (a == PWA) begin
      if (m_dis) begin
        m_pw = m_pw & d; m_dis = 1'b0; e_pass = 1'b1;
      end else if (m_tries != 3'b000) begin
        if (d == m_pw) begin m_bad = 1'b0; e_pass = 1'b1; end
        else m_tries = m_tries & {m_tries[1:0], 1'b0};
      end
    end
  endtask

  task automatic power_on();
    @(negedge clk); nv_init_n = 1'b0;
    @(negedge clk); nv_init_n = 1'b1;
    m_pw = 16'hFFFF; m_dis = 1'b1; m_bad = 1'b1; m_tries = 3'b111;
    check_state("R1 init");
  endtask

  task automatic op(string tag, logic [23:0] a, logic [15:0] d);
    req = 1'b1; addr = a; {pw_hi, pw_lo} = d;
    model(a, d);
    @(negedge clk); req = 1'b0;
    check({tag, " done R8"}, done, 1);
    check({tag, " pass"}, pass, e_pass);
    check_state(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    check("R8 done drops", done, 0);
    check("R8 pass drops", pass, 0);
  endtask

  task automatic reset_with_req(logic [15:0] d);
    rst_n = 1'b0; req = 1'b1; addr = PWA; {pw_hi, pw_lo} = d;
    @(negedge clk); req = 1'b0;
    check("R9 done in reset", done, 0);
    check("R9 pass in reset", pass, 0);
    @(negedge clk); rst_n = 1'b1;
    check_state("R9 R10 reset keeps state");
  endtask

  function automatic logic [15:0] wrong(logic [15:0] p);
    logic [15:0] w = 16'($urandom);
    return (w == p) ? ~p : w;
  endfunction

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    power_on();
    idle();

    op("R7 other addr", 24'h1FFD, 16'h1234);
    op("R2 store", PWA, 16'hA55A);
    idle();
    op("R4 miss1", PWA, 16'h0000);
    op("R4 miss2", PWA, 16'hA55B);
    op("R4 miss3", PWA, 16'h5AA5);
    op("R5 correct rejected", PWA, 16'hA55A);
    op("R5 miss after lock", PWA, 16'h1111);
    reset_with_req(16'hA55A);

    power_on();
    reset_with_req(16'hBEEF);
    op("R2 store", PWA, 16'hBEEF);
    op("R3 match", PWA, 16'hBEEF);
    op("R4 miss after ok", PWA, 16'h0001);
    op("R4 miss after ok", PWA, 16'h0002);
    op("R5 last try drops test_en", PWA, 16'h0003);
    op("R5 correct after lock", PWA, 16'hBEEF);
    power_on();
    check("R10 init restores tries", st_tries, 3'b111);

    for (int ep = 0; ep < 300; ep++) begin
      power_on();
      if ($urandom % 10 != 0) op("R2 store", PWA, 16'($urandom));
      for (int k = 0; k < 3 + int'($urandom % 8); k++) begin
        case ($urandom % 10)
          0, 1, 2, 3: op("R4 random miss", PWA, wrong(m_pw));
          4, 5, 6:    op("R3 random match", PWA, m_pw);
          7:          op("R7 random other", 24'($urandom) | 24'h200000, m_pw);
          8:          reset_with_req(($urandom % 2) ? m_pw : wrong(m_pw));
          default:    idle();
        endcase
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule